// File: doc/BRIEF.md
# Display Identification Block Fetcher

This block fetches one 128-byte identification block from an attached display over the two-wire display data channel. A caller gives it a linear block number and a start pulse. The block turns the number into a segment and a byte offset and reads the whole block as a run of short bursts. Each burst uses the explicit-offset form of the enhanced read. First the segment is written to the segment-pointer device. Then the starting offset is written to the data device. Then the burst's bytes are read back after a repeated start. The received bytes leave the block as an indexed byte stream. A single done pulse, qualified by error and timeout flags, ends the fetch.

Bit-level clock and data generation sits in a separate byte engine. This block drives that engine through a request/acknowledge command port. The port offers four operations: start condition, stop condition, write one byte, and read one byte. For a write, the engine reports whether the slave acknowledged. For a read, the block tells the engine whether to answer with a NACK. A clock-divider setting is captured at the start of a fetch and passed on to the engine unchanged.

Top module: `edid_block_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done`, `error`, `timeout`, `eng_req` and `rx_valid` are all low.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle and captures `block_num` and `bus_div`. `eng_div` then holds the captured divider for the whole fetch. A `start` seen while busy is ignored and changes neither the block being read nor `eng_div`.
- R3: The segment byte equals `block_num` shifted right by one. The first offset is 0 for an even block and 128 for an odd block.
- R4: Every burst issues exactly this command order, with operation codes START=0, STOP=1, WRITE=2 and READ=3: START; WRITE 0x60 (segment-pointer device 0x30 with the write bit); WRITE segment; START; WRITE 0xA0 (data device 0x50, write); WRITE offset; START; WRITE 0xA1 (data device 0x50, read); one READ per byte of the burst; STOP.
- R5: A block is fetched as 8 bursts of 16 bytes. The offset written in burst k equals the first offset plus 16·k.
- R6: `eng_last` is high on the final READ of each burst and on no other command.
- R7: Each received byte appears for one cycle on `rx_data` with `rx_valid`. `rx_index` counts 0 upward in receive order, and byte i is the byte stored at offset (first offset + i).
- R8: If the engine reports a NACK on any WRITE, the next command is STOP. The fetch then ends with `done` and `error` high, and no further bursts are started.
- R9: A burst counter measures cycles from the launch of each burst. If it reaches `wdog_limit` before the burst finishes, the fetch is abandoned: `eng_req` drops, and `done`, `error` and `timeout` pulse together.
- R10: `done` is a single-cycle pulse in the cycle in which `busy` first reads low. `error` and `timeout` are high only together with `done`.
- R11: Once `eng_req` is raised, it stays high with a stable operation and write byte until `eng_ack` is seen, unless the watchdog abandons the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a fetch (honoured only while idle) |
| block_num | input | 8 | Linear block number to fetch |
| bus_div | input | DIV_W | Bus clock divider setting for the byte engine |
| wdog_limit | input | WDOG_W | Per-burst cycle limit |
| eng_req | output | 1 | Command request to the byte engine |
| eng_op | output | 2 | Command code: 0 start, 1 stop, 2 write, 3 read |
| eng_wdata | output | 8 | Byte to send on a write command |
| eng_last | output | 1 | Answer this read with a NACK |
| eng_div | output | DIV_W | Divider captured at start |
| eng_ack | input | 1 | Engine finished the current command (one-cycle pulse) |
| eng_nack | input | 1 | Slave did not acknowledge the written byte (valid with eng_ack) |
| eng_rdata | input | 8 | Byte read (valid with eng_ack) |
| rx_valid | output | 1 | A received byte is presented |
| rx_data | output | 8 | Received byte |
| rx_index | output | 7 | Position of the byte within the block |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Fetch finished (one-cycle pulse) |
| error | output | 1 | Fetch failed (with done) |
| timeout | output | 1 | Failure was a watchdog expiry (with done) |

## Verification
The bench builds the block with a 128-byte block, 16-byte bursts and an 8-bit divider. It uses a 12-bit watchdog, so a limit of a few dozen cycles can fire while normal bursts stay well under the 1000-cycle limit used elsewhere. This even split gives eight full bursts per block. That makes it practical to sweep sixteen consecutive block numbers plus the two highest, covering both offset halves and segment values up to 127, under three engine latencies. A NACK is injected at every write position of a burst and at a segment write deep in the block. A stalled engine covers expiry. Every byte value and every command is derived arithmetically from the block number and the burst position.

// File: rtl/edid_rd_pkg.sv
// Shared types for the identification block fetcher.
// Assumes: byte engine command codes are fixed by the interface (0..3).
package edid_rd_pkg;

    // Commands understood by the external byte engine
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } eng_op_e;

    // Positions in one explicit-offset burst; order is the wire order
    typedef enum logic [3:0] {
        ST_START_SEG = 4'd0,
        ST_SEG_DEV   = 4'd1,
        ST_SEG_NUM   = 4'd2,
        ST_START_OFF = 4'd3,
        ST_DEV_WR    = 4'd4,
        ST_OFFSET    = 4'd5,
        ST_START_RD  = 4'd6,
        ST_DEV_RD    = 4'd7,
        ST_READ      = 4'd8,
        ST_STOP      = 4'd9
    } burst_step_e;

    // Device address byte: 7-bit address followed by the read bit
    function automatic logic [7:0] dev_byte(input logic [6:0] addr, input logic rd);
        return {addr, rd};
    endfunction

endpackage

// File: rtl/edid_addr_map.sv
// Maps a linear block number and a burst index onto segment, byte offset
// and burst length. Purely combinational.
// Assumes: two blocks per segment; offsets fit in eight bits.
module edid_addr_map #(
    parameter int BLOCK_BYTES = 128,
    parameter int BURST_LEN   = 16,
    parameter int NUM_BURSTS  = 8,
    parameter int NB_W        = 3,
    parameter int LEN_W       = 5
) (
    input  logic [7:0]       block_num,
    input  logic [NB_W-1:0]  burst_idx,
    output logic [7:0]       seg,
    output logic [7:0]       offset,
    output logic [LEN_W-1:0] len,
    output logic             last_burst
);
    localparam int TAIL = BLOCK_BYTES - (NUM_BURSTS - 1) * BURST_LEN;

    logic [15:0] off_full;

    // Segment from the upper bits, offset from the low bit plus burst position
    always_comb begin
        seg      = {1'b0, block_num[7:1]};
        off_full = (block_num[0] ? 16'(BLOCK_BYTES) : 16'd0)
                 + 16'(burst_idx) * 16'(BURST_LEN);
        offset   = off_full[7:0];
    end

    assign last_burst = (burst_idx == NB_W'(NUM_BURSTS - 1));

    // Burst length: constant for an even split, shortened tail otherwise
    generate
        if (TAIL == BURST_LEN) begin : g_even
            assign len = LEN_W'(BURST_LEN);
        end else begin : g_tail
            assign len = last_burst ? LEN_W'(TAIL) : LEN_W'(BURST_LEN);
        end
    endgenerate

endmodule

// File: rtl/edid_burst_seq.sv
// Issues one explicit-offset burst to the byte engine: segment write,
// offset write, repeated-start read of len bytes, stop. A write NACK
// skips straight to stop and flags the burst as failed.
// Assumes: engine acknowledges each command with a one-cycle eng_ack.
module edid_burst_seq
    import edid_rd_pkg::*;
#(
    parameter int         LEN_W    = 5,
    parameter logic [6:0] SEG_DEV  = 7'h30,
    parameter logic [6:0] EDID_DEV = 7'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             abort,
    input  logic [7:0]       seg,
    input  logic [7:0]       offset,
    input  logic [LEN_W-1:0] len,
    output logic             eng_req,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_last,
    input  logic             eng_ack,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [LEN_W-1:0] rx_cnt,
    output logic             fin,
    output logic             fin_err
);
    logic             active;
    burst_step_e      step;
    eng_op_e          op_e;
    logic [LEN_W-1:0] rd_cnt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_m1;
    logic [7:0]       seg_q;
    logic [7:0]       off_q;
    logic             nacked;

    assign len_m1   = len_q - LEN_W'(1);
    assign eng_req  = active;
    assign eng_op   = op_e;
    assign eng_last = active && (step == ST_READ) && (rd_cnt == len_m1);

    // Command code and byte for the current burst position
    always_comb begin
        op_e      = OP_START;
        eng_wdata = 8'h00;
        case (step)
            ST_SEG_DEV: begin op_e = OP_WRITE; eng_wdata = dev_byte(SEG_DEV, 1'b0);  end
            ST_SEG_NUM: begin op_e = OP_WRITE; eng_wdata = seg_q;                    end
            ST_DEV_WR:  begin op_e = OP_WRITE; eng_wdata = dev_byte(EDID_DEV, 1'b0); end
            ST_OFFSET:  begin op_e = OP_WRITE; eng_wdata = off_q;                    end
            ST_DEV_RD:  begin op_e = OP_WRITE; eng_wdata = dev_byte(EDID_DEV, 1'b1); end
            ST_READ:    op_e = OP_READ;
            ST_STOP:    op_e = OP_STOP;
            default:    op_e = OP_START;
        endcase
    end

    // Burst progress: advance on each acknowledge, divert to stop on NACK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            step     <= ST_START_SEG;
            rd_cnt   <= '0;
            len_q    <= '0;
            seg_q    <= '0;
            off_q    <= '0;
            nacked   <= 1'b0;
            fin      <= 1'b0;
            fin_err  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_cnt   <= '0;
        end else begin
            fin      <= 1'b0;
            rx_valid <= 1'b0;
            if (abort) begin
                active <= 1'b0;
            end else if (!active) begin
                if (launch) begin
                    active <= 1'b1;
                    step   <= ST_START_SEG;
                    rd_cnt <= '0;
                    nacked <= 1'b0;
                    seg_q  <= seg;
                    off_q  <= offset;
                    len_q  <= len;
                end
            end else if (eng_ack) begin
                if (step == ST_STOP) begin
                    active  <= 1'b0;
                    fin     <= 1'b1;
                    fin_err <= nacked;
                end else if (op_e == OP_WRITE && eng_nack) begin
                    nacked <= 1'b1;
                    step   <= ST_STOP;
                end else if (step == ST_READ) begin
                    rx_valid <= 1'b1;
                    rx_data  <= eng_rdata;
                    rx_cnt   <= rd_cnt;
                    if (rd_cnt == len_m1) begin
                        step <= ST_STOP;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end else begin
                    step <= burst_step_e'(4'(step) + 4'd1);
                end
            end
        end
    end

endmodule

// File: rtl/edid_watchdog.sv
// Per-burst cycle counter. Cleared on each burst launch, counts while
// enabled, saturates, and flags expiry once the count reaches the limit.
module edid_watchdog #(
    parameter int WDOG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [WDOG_W-1:0] limit,
    output logic              expired
);
    logic [WDOG_W-1:0] cnt;

    // Saturating cycle count since the last launch
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable) begin
            cnt <= '0;
        end else if (cnt != {WDOG_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = enable && !clear && (cnt >= limit);

endmodule

// File: rtl/edid_block_reader.sv
// Top of the identification block fetcher. Sequences the bursts of one
// block, tags received bytes with their block index, and reports the end
// of the fetch with done/error/timeout.
// Assumes: block size is a multiple-of-two byte count of at most 128.
module edid_block_reader
    import edid_rd_pkg::*;
#(
    parameter int         BLOCK_BYTES = 128,
    parameter int         BURST_LEN   = 16,
    parameter int         DIV_W       = 8,
    parameter int         WDOG_W      = 16,
    parameter logic [6:0] SEG_DEV     = 7'h30,
    parameter logic [6:0] EDID_DEV    = 7'h50
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [7:0]                     block_num,
    input  logic [DIV_W-1:0]               bus_div,
    input  logic [WDOG_W-1:0]              wdog_limit,
    output logic                           eng_req,
    output logic [1:0]                     eng_op,
    output logic [7:0]                     eng_wdata,
    output logic                           eng_last,
    output logic [DIV_W-1:0]               eng_div,
    input  logic                           eng_ack,
    input  logic                           eng_nack,
    input  logic [7:0]                     eng_rdata,
    output logic                           rx_valid,
    output logic [7:0]                     rx_data,
    output logic [$clog2(BLOCK_BYTES)-1:0] rx_index,
    output logic                           busy,
    output logic                           done,
    output logic                           error,
    output logic                           timeout
);
    localparam int NUM_BURSTS = (BLOCK_BYTES + BURST_LEN - 1) / BURST_LEN;
    localparam int NB_W       = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1;
    localparam int LEN_W      = $clog2(BURST_LEN + 1);
    localparam int IDX_W      = $clog2(BLOCK_BYTES);

    logic             run;
    logic             launch;
    logic [7:0]       blk_q;
    logic [DIV_W-1:0] div_q;
    logic [NB_W-1:0]  burst_idx;
    logic [7:0]       seg;
    logic [7:0]       offset;
    logic [LEN_W-1:0] len;
    logic             last_burst;
    logic [LEN_W-1:0] rx_cnt;
    logic             fin;
    logic             fin_err;
    logic             wd_exp;

    edid_addr_map #(
        .BLOCK_BYTES(BLOCK_BYTES),
        .BURST_LEN  (BURST_LEN),
        .NUM_BURSTS (NUM_BURSTS),
        .NB_W       (NB_W),
        .LEN_W      (LEN_W)
    ) u_map (
        .block_num (blk_q),
        .burst_idx (burst_idx),
        .seg       (seg),
        .offset    (offset),
        .len       (len),
        .last_burst(last_burst)
    );

    edid_burst_seq #(
        .LEN_W   (LEN_W),
        .SEG_DEV (SEG_DEV),
        .EDID_DEV(EDID_DEV)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .abort    (wd_exp),
        .seg      (seg),
        .offset   (offset),
        .len      (len),
        .eng_req  (eng_req),
        .eng_op   (eng_op),
        .eng_wdata(eng_wdata),
        .eng_last (eng_last),
        .eng_ack  (eng_ack),
        .eng_nack (eng_nack),
        .eng_rdata(eng_rdata),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_cnt   (rx_cnt),
        .fin      (fin),
        .fin_err  (fin_err)
    );

    edid_watchdog #(
        .WDOG_W(WDOG_W)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .enable (run),
        .limit  (wdog_limit),
        .expired(wd_exp)
    );

    assign busy     = run;
    assign eng_div  = div_q;
    assign rx_index = IDX_W'(32'(burst_idx) * BURST_LEN + 32'(rx_cnt));

    // Fetch control: accept start, step through bursts, report the outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            launch    <= 1'b0;
            blk_q     <= '0;
            div_q     <= '0;
            burst_idx <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            launch  <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
            timeout <= 1'b0;
            if (!run) begin
                if (start) begin
                    run       <= 1'b1;
                    blk_q     <= block_num;
                    div_q     <= bus_div;
                    burst_idx <= '0;
                    launch    <= 1'b1;
                end
            end else if (wd_exp) begin
                run     <= 1'b0;
                done    <= 1'b1;
                error   <= 1'b1;
                timeout <= 1'b1;
            end else if (fin) begin
                if (fin_err || last_burst) begin
                    run   <= 1'b0;
                    done  <= 1'b1;
                    error <= fin_err;
                end else begin
                    burst_idx <= burst_idx + 1'b1;
                    launch    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/edid_block_reader_chk.sv
// Protocol checker for the fetcher, attached to every instance by bind.
module edid_block_reader_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             timeout,
    input logic             eng_req,
    input logic             eng_ack,
    input logic             eng_nack,
    input logic [1:0]       eng_op,
    input logic [7:0]       eng_wdata,
    input logic             eng_last,
    input logic [DIV_W-1:0] eng_div,
    input logic             rx_valid
);
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));  // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);  // R10
    AST_TMO_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> error);  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eng_req && !rx_valid));  // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=>
            ((eng_req && $stable(eng_op) && $stable(eng_wdata)) || timeout));  // R11
    AST_LAST_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        eng_last |-> (eng_req && eng_op == 2'd3));  // R6
    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack && eng_nack && eng_op == 2'd2) |=>
            ((eng_req && eng_op == 2'd1) || timeout));  // R8
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(eng_div));  // R2
endmodule

bind edid_block_reader edid_block_reader_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .timeout  (timeout),
    .eng_req  (eng_req),
    .eng_ack  (eng_ack),
    .eng_nack (eng_nack),
    .eng_op   (eng_op),
    .eng_wdata(eng_wdata),
    .eng_last (eng_last),
    .eng_div  (eng_div),
    .rx_valid (rx_valid)
);

// File: tb/edid_block_reader_bench.sv
// Bench: byte-engine model plus sweeps over block numbers, latencies,
// NACK positions and a stalled engine.
module edid_block_reader_bench;
    localparam int BLK = 128;
    localparam int BL  = 16;
    localparam int DW  = 8;
    localparam int WW  = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [7:0]    block_num;
    logic [DW-1:0] bus_div;
    logic [WW-1:0] wdog_limit;
    logic          eng_req;
    logic [1:0]    eng_op;
    logic [7:0]    eng_wdata;
    logic          eng_last;
    logic [DW-1:0] eng_div;
    logic          eng_ack;
    logic          eng_nack;
    logic [7:0]    eng_rdata;
    logic          rx_valid;
    logic [7:0]    rx_data;
    logic [6:0]    rx_index;
    logic          busy, done, error, timeout;

    always #5 clk = ~clk;

    edid_block_reader #(.BLOCK_BYTES(BLK), .BURST_LEN(BL), .DIV_W(DW), .WDOG_W(WW)) u_edid_block_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .block_num(block_num),
        .bus_div(bus_div), .wdog_limit(wdog_limit),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_last(eng_last), .eng_div(eng_div), .eng_ack(eng_ack),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_index(rx_index),
        .busy(busy), .done(done), .error(error), .timeout(timeout)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input int sg, input int addr);
        return 8'(sg * 37 + addr * 5 + 3);
    endfunction

    // Test configuration, written only by the main sequence
    int lat_cfg = 0;
    int nack_at = 0;
    int stall = 0;
    int exp_seg = 0;
    int exp_base = 0;

    // Byte-engine model: answers requests and checks each command (R3-R6)
    int pos, mb, wr_cnt, lat;
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_ack <= 1'b0; eng_nack <= 1'b0; eng_rdata <= 8'h00;
            pos = 0; mb = 0; wr_cnt = 0; lat = 0;
        end else begin
            if (start && !busy) begin
                pos = 0; mb = 0; wr_cnt = 0; lat = 0;
            end
            if (eng_ack) begin
                eng_ack <= 1'b0; eng_nack <= 1'b0;
            end else if (eng_req && stall == 0) begin
                if (lat < lat_cfg) begin
                    lat++;
                end else begin
                    int eop;
                    int ed;
                    lat = 0;
                    ed = 0;
                    case (pos)
                        0, 3, 6: eop = 0;
                        1: begin eop = 2; ed = 8'h60; end
                        2: begin eop = 2; ed = exp_seg; end
                        4: begin eop = 2; ed = 8'hA0; end
                        5: begin eop = 2; ed = (exp_base + mb * BL) & 255; end
                        7: begin eop = 2; ed = 8'hA1; end
                        8 + BL: eop = 1;
                        default: eop = 3;
                    endcase
                    check(int'(eng_op) == eop, "R4 command order", int'(eng_op), eop);
                    if (eop == 2 && pos == 2)
                        check(int'(eng_wdata) == ed, "R3 segment byte", int'(eng_wdata), ed);
                    else if (eop == 2 && pos == 5)
                        check(int'(eng_wdata) == ed, "R5 burst offset", int'(eng_wdata), ed);
                    else if (eop == 2)
                        check(int'(eng_wdata) == ed, "R4 device byte", int'(eng_wdata), ed);
                    if (eop == 3) begin
                        check(eng_last == (pos == 8 + BL - 1), "R6 final read nack",
                              int'(eng_last), int'(pos == 8 + BL - 1));
                        eng_rdata <= mem_byte(exp_seg, exp_base + mb * BL + pos - 8);
                    end
                    if (eop == 2) begin
                        wr_cnt++;
                        if (wr_cnt == nack_at) begin
                            eng_nack <= 1'b1;
                            pos = 8 + BL;
                        end else begin
                            pos++;
                        end
                    end else if (pos == 8 + BL) begin
                        pos = 0;
                        mb++;
                    end else begin
                        pos++;
                    end
                    eng_ack <= 1'b1;
                end
            end
        end
    end

    // Output monitor, sampled on the falling edge (R7, R10)
    int rx_seen = 0;
    int done_cnt = 0;
    bit err_seen = 1'b0;
    bit tmo_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !busy) begin
                rx_seen = 0; done_cnt = 0; err_seen = 1'b0; tmo_seen = 1'b0;
            end
            if (rx_valid) begin
                check(int'(rx_index) == rx_seen, "R7 byte index", int'(rx_index), rx_seen);
                check(rx_data == mem_byte(exp_seg, exp_base + rx_seen), "R7 byte value",
                      int'(rx_data), int'(mem_byte(exp_seg, exp_base + rx_seen)));
                rx_seen++;
            end
            if (done) begin
                done_cnt++;
                err_seen = error;
                tmo_seen = timeout;
                check(!busy, "R10 busy low with done", int'(busy), 0);
            end
            if ((error || timeout) && !done)
                check(1'b0, "R10 flag outside done", 1, 0);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One fetch: configure, start, optionally poke start mid-run, check outcome
    task automatic run_block(input int blk, input int lat_v, input int nk,
                             input int stl, input int limit, input int poke);
        int cyc;
        int exp_rx;
        exp_seg = blk >> 1;
        exp_base = (blk & 1) ? 128 : 0;
        lat_cfg = lat_v; nack_at = nk; stall = stl;
        wdog_limit = WW'(limit);
        block_num = 8'(blk);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(busy, "R2 busy after start", int'(busy), 1);
        check(eng_div == bus_div, "R2 divider captured", int'(eng_div), int'(bus_div));
        cyc = 0;
        while (done_cnt == 0 && cyc < 20000) begin
            if (poke > 0 && cyc == poke) begin
                @(posedge clk); #1 start = 1'b1; block_num = 8'(blk ^ 9); bus_div = 8'd3;
                @(posedge clk); #1 start = 1'b0;
                @(negedge clk);
                check(eng_div == 8'd7, "R2 divider held while busy", int'(eng_div), 7);
                cyc += 2;
            end
            @(negedge clk);
            cyc++;
        end
        repeat (3) @(negedge clk);
        if (stl != 0) exp_rx = 0;
        else if (nk > 0) exp_rx = ((nk - 1) / 5) * BL;
        else exp_rx = BLK;
        check(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
        check(err_seen == (nk > 0 || stl != 0), "R8 error outcome", int'(err_seen), int'(nk > 0 || stl != 0));
        check(tmo_seen == (stl != 0), "R9 timeout outcome", int'(tmo_seen), int'(stl != 0));
        check(rx_seen == exp_rx, "R5 received byte count", rx_seen, exp_rx);
        check(!busy && !eng_req, "R8 idle after fetch", int'(busy), 0);
        if (stl != 0)
            check(cyc <= limit + 6, "R9 expiry latency", cyc, limit + 6);
        stall = 0;
    endtask

    // Run-away guard
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; block_num = 8'd0; bus_div = 8'd7; wdog_limit = WW'(1000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy, done, error, timeout, eng_req, rx_valid} == 6'b0, "R1 reset state",
              int'({busy, done, error, timeout, eng_req, rx_valid}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, error, timeout, eng_req, rx_valid} == 6'b0, "R1 after reset",
              int'({busy, done, error, timeout, eng_req, rx_valid}), 0);

        for (int b = 0; b < 16; b++) run_block(b, b % 3, 0, 0, 1000, 0);
        run_block(254, 1, 0, 0, 1000, 0);
        run_block(255, 2, 0, 0, 1000, 0);

        for (int k = 1; k <= 5; k++) run_block(6, 1, k, 0, 1000, 0);
        run_block(3, 0, 17, 0, 1000, 0);

        run_block(4, 0, 0, 1, 40, 0);
        run_block(7, 0, 0, 0, 1000, 0);

        bus_div = 8'd7;
        run_block(5, 1, 0, 0, 1000, 300);
        run_block(11, 0, 0, 0, 1000, 0);

        finish_run();
    end

endmodule